// File: doc/BRIEF.md
# Macroblock Edge Smoothing Filter Datapath

This block smooths one line of eight 8-bit samples that straddles a macroblock boundary. Three samples lie on each side of the edge, and one outer sample on each side passes through. A new line can enter on every clock cycle. Two qualifier bits arrive with each line from an upstream mask generator. The first enables the filter. The second marks a high-variance edge.

On a high-variance edge, only the two samples next to the boundary are nudged, by a short rounded step. On other lines, a weighted correction with weights 27, 18 and 9 is applied to the three samples on each side. The pair nearest the edge gets the largest share. All arithmetic is done on samples biased into signed form. Every intermediate value saturates to the signed byte range, and every result saturates to 0..255.

The block is a two-stage pipeline with a fixed latency. The first stage computes the base value and the step sizes. The second stage applies the steps to the samples. It holds no state other than its pipeline registers. Mask generation and access to picture memory are left to neighbouring blocks.

Top module: `mbedge_smoother`

## Requirements
- R1: Each sample is biased to signed form (value minus 128). The base value w is formed as follows: d = sat(p1 − q1); e = sat(q0 − p0); then w = sat(sat(sat(d + e) + e) + e). Here sat limits a value to −128..127. The line is packed with p3 in lineIn[7:0], p2 in [15:8], p1 in [23:16], p0 in [31:24], q0 in [39:32], q1 in [47:40], q2 in [55:48] and q3 in [63:56]. lineOut uses the same packing.
- R2: When filtEn is 0, w is treated as 0, and the output line equals the input line.
- R3: When highVar is 1, the two steps are s4 = sat(w+4)>>>3 and s3 = sat(w+3)>>>3. The output p0 is p0+s3 and the output q0 is q0−s4. p1, q1, p2 and q2 are unchanged.
- R4: When highVar is 0, the step is a0 = sat((27·w + 63)>>>7), computed with 16-bit signed intermediates. The output p0 is p0+a0 and the output q0 is q0−a0.
- R5: When highVar is 0, the step is a1 = sat((18·w + 63)>>>7). The output p1 is p1+a1 and the output q1 is q1−a1.
- R6: When highVar is 0, the step is a2 = sat((9·w + 63)>>>7). The output p2 is p2+a2 and the output q2 is q2−a2.
- R7: Every sample update saturates to the unsigned range 0..255.
- R8: p3 and q3 leave the block unchanged.
- R9: validOut is high exactly two cycles after validIn was sampled high. lineOut changes only when a valid result arrives, and otherwise holds its last value.
- R10: While rstN is low, validOut is 0 and lineOut is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on the rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| validIn | input | 1 | A line is presented this cycle |
| filtEn | input | 1 | Filter enable from the mask generator |
| highVar | input | 1 | High-variance edge flag from the mask generator |
| lineIn | input | 64 | Eight samples, p3 in the low byte through q3 in the high byte |
| validOut | output | 1 | lineOut carries a filtered line |
| lineOut | output | 64 | Filtered samples, with the same packing as lineIn |

## Verification
Every filtered line is due exactly two rising edges after the edge that sampled it, and validOut rises at the same moment. The bench drives inputs on the falling edge. It keeps a two-deep queue of its own expected results and compares lineOut and validOut at the falling edge two cycles after each line was driven. On cycles with no valid output, it checks that lineOut still holds the last expected line. That check covers gaps in the stream as well as back-to-back lines.

// File: rtl/mbedge_pkg.sv
package mbedge_pkg;

  localparam int SAMPLE_BITS = 8;
  localparam int LINE_SAMPLES = 8;
  localparam int LINE_BITS = SAMPLE_BITS * LINE_SAMPLES;

  typedef struct packed {
    logic load1;
    logic load2;
  } strobe_t;

  function automatic logic signed [15:0] sx16(input logic signed [7:0] v);
    return {{8{v[7]}}, v};
  endfunction

  function automatic logic signed [7:0] satS8(input logic signed [15:0] v);
    if (v > 16'sd127) return 8'sd127;
    if (v < -16'sd128) return -8'sd128;
    return v[7:0];
  endfunction

  function automatic logic signed [7:0] toSigned(input logic [7:0] u);
    return $signed(u ^ 8'h80);
  endfunction

  function automatic logic [7:0] clampU8(input logic signed [9:0] t);
    if (t < 10'sd0) return 8'd0;
    if (t > 10'sd255) return 8'd255;
    return t[7:0];
  endfunction

  function automatic logic [7:0] addU(input logic [7:0] u, input logic signed [7:0] d);
    logic signed [9:0] t;
    t = $signed({2'b00, u}) + $signed({{2{d[7]}}, d});
    return clampU8(t);
  endfunction

  function automatic logic [7:0] subU(input logic [7:0] u, input logic signed [7:0] d);
    logic signed [9:0] t;
    t = $signed({2'b00, u}) - $signed({{2{d[7]}}, d});
    return clampU8(t);
  endfunction

endpackage

// File: rtl/mbedge_ctrl.sv
module mbedge_ctrl
  import mbedge_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    validIn,
  output strobe_t strobe,
  output logic    validOut
);

  logic s1Valid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Valid  <= 1'b0;
      validOut <= 1'b0;
    end else begin
      s1Valid  <= validIn;
      validOut <= s1Valid;
    end
  end

  always_comb begin
    strobe.load1 = validIn;
    strobe.load2 = s1Valid;
  end

  // R9: a sampled line comes out exactly two edges later
  p_latency_r9: assert property (@(posedge clk) disable iff (!rstN)
    validIn |-> ##2 validOut);
  // R9: no output without an input two edges earlier
  p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rstN)
    !validIn |-> ##2 !validOut);

endmodule

// File: rtl/mbedge_datapath.sv
module mbedge_datapath
  import mbedge_pkg::*;
#(
  parameter int NEAR_WEIGHT = 27,
  parameter int MID_WEIGHT  = 18,
  parameter int FAR_WEIGHT  = 9,
  parameter int ROUND_BIAS  = 63,
  parameter int ROUND_SHIFT = 7,
  parameter int SHORT_SHIFT = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strobe,
  input  logic [LINE_BITS-1:0] lineIn,
  input  logic                 filtEn,
  input  logic                 highVar,
  output logic [LINE_BITS-1:0] lineOut
);

  localparam int NUM_TAPS = 3;

  function automatic int tapWeight(input int idx);
    case (idx)
      0:       return NEAR_WEIGHT;
      1:       return MID_WEIGHT;
      default: return FAR_WEIGHT;
    endcase
  endfunction

  // ---------------- stage one: base value and step sizes ----------------
  logic signed [7:0] sP1, sP0, sQ0, sQ1;
  logic signed [7:0] outerDiff, innerDiff, acc1, acc2, acc3;
  logic signed [7:0] wAll, wShort, wLong;
  logic signed [7:0] shortQ, shortP, stepQ, stepP;
  logic signed [7:0] tapVal [NUM_TAPS];

  always_comb begin
    sP1 = toSigned(lineIn[23:16]);
    sP0 = toSigned(lineIn[31:24]);
    sQ0 = toSigned(lineIn[39:32]);
    sQ1 = toSigned(lineIn[47:40]);
    outerDiff = satS8(sx16(sP1) - sx16(sQ1));
    innerDiff = satS8(sx16(sQ0) - sx16(sP0));
    acc1 = satS8(sx16(outerDiff) + sx16(innerDiff));
    acc2 = satS8(sx16(acc1) + sx16(innerDiff));
    acc3 = satS8(sx16(acc2) + sx16(innerDiff));
    wAll   = filtEn ? acc3 : 8'sd0;
    wShort = highVar ? wAll : 8'sd0;
    wLong  = highVar ? 8'sd0 : wAll;
    shortQ = satS8(sx16(wShort) + 16'sd4);
    shortP = satS8(sx16(wShort) + 16'sd3);
    stepQ  = shortQ >>> SHORT_SHIFT;
    stepP  = shortP >>> SHORT_SHIFT;
  end

  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
    localparam logic signed [15:0] WEIGHT = 16'(tapWeight(g));
    localparam logic signed [15:0] BIAS   = 16'(ROUND_BIAS);
    logic signed [15:0] product, biased;
    always_comb begin
      product   = sx16(wLong) * WEIGHT;
      biased    = product + BIAS;
      tapVal[g] = satS8(biased >>> ROUND_SHIFT);
    end
  end

  logic [LINE_BITS-1:0] s1Line;
  logic signed [7:0]    s1DeltaP0, s1DeltaQ0, s1Tap1, s1Tap2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Line    <= '0;
      s1DeltaP0 <= '0;
      s1DeltaQ0 <= '0;
      s1Tap1    <= '0;
      s1Tap2    <= '0;
    end else if (strobe.load1) begin
      s1Line    <= lineIn;
      s1DeltaP0 <= highVar ? stepP : tapVal[0];
      s1DeltaQ0 <= highVar ? stepQ : tapVal[0];
      s1Tap1    <= tapVal[1];
      s1Tap2    <= tapVal[2];
    end
  end

  // ---------------- stage two: apply steps ----------------
  logic [LINE_BITS-1:0] nextLine;

  always_comb begin
    nextLine[7:0]   = s1Line[7:0];
    nextLine[15:8]  = addU(s1Line[15:8],  s1Tap2);
    nextLine[23:16] = addU(s1Line[23:16], s1Tap1);
    nextLine[31:24] = addU(s1Line[31:24], s1DeltaP0);
    nextLine[39:32] = subU(s1Line[39:32], s1DeltaQ0);
    nextLine[47:40] = subU(s1Line[47:40], s1Tap1);
    nextLine[55:48] = subU(s1Line[55:48], s1Tap2);
    nextLine[63:56] = s1Line[63:56];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lineOut <= '0;
    else if (strobe.load2) lineOut <= nextLine;
  end

  // R2: a disabled line carries zero steps into stage two
  p_disabled_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load1 && !filtEn) |=> (s1DeltaP0 == 0 && s1DeltaQ0 == 0 && s1Tap1 == 0 && s1Tap2 == 0));
  // R3: a high-variance line gets no outer taps
  p_hev_no_taps_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load1 && highVar) |=> (s1Tap1 == 0 && s1Tap2 == 0));
  // R8: the outer samples pass through stage two unchanged
  p_passthru_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load2 |=> (lineOut[7:0] == $past(s1Line[7:0]) && lineOut[63:56] == $past(s1Line[63:56])));
  // R9: the output holds when no result arrives
  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load2 |=> $stable(lineOut));

endmodule

// File: rtl/mbedge_smoother.sv
module mbedge_smoother
  import mbedge_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        validIn,
  input  logic        filtEn,
  input  logic        highVar,
  input  logic [63:0] lineIn,
  output logic        validOut,
  output logic [63:0] lineOut
);

  strobe_t strobe;

  mbedge_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .validIn  (validIn),
    .strobe   (strobe),
    .validOut (validOut)
  );

  mbedge_datapath u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .lineIn  (lineIn),
    .filtEn  (filtEn),
    .highVar (highVar),
    .lineOut (lineOut)
  );

endmodule

// File: tb/mbedge_smoother_tb.sv
module mbedge_smoother_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;

  // {filtEn, highVar, line}; line bytes from the left: q3 q2 q1 q0 p0 p1 p2 p3
  localparam logic [65:0] VEC_IN [NVEC] = '{
    {2'b10, 64'h8080_8088_7880_8080},
    {2'b11, 64'h8080_8088_7880_8080},
    {2'b00, 64'h8080_8088_7880_8080},
    {2'b10, 64'h1405_00FF_FAFF_FA0A},
    {2'b11, 64'h8080_8078_8880_8080},
    {2'b10, 64'h8080_8078_8880_8080}
  };
  localparam logic [63:0] VEC_EXP [NVEC] = '{
    64'h807D_797E_8287_8380,
    64'h8080_8082_7E80_8080,
    64'h8080_8088_7880_8080,
    64'h1400_00E4_FFFF_FF0A,
    64'h8080_807E_8280_8080,
    64'h8083_8782_7E79_7D80
  };
  string vecTag [NVEC] = '{"R4,R5,R6", "R3", "R2", "R7,R8", "R3", "R6"};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic validIn = 1'b0, filtEn = 1'b0, highVar = 1'b0;
  logic [63:0] lineIn = '0;
  logic validOut;
  logic [63:0] lineOut;

  int nChecks = 0, nFails = 0;
  bit finished = 1'b0;

  bit pv1 = 0, pv2 = 0;
  logic [63:0] pe1 = '0, pe2 = '0, lastExp = '0;
  string pt1 = "", pt2 = "";

  always #(CLK_PERIOD/2) clk = ~clk;

  mbedge_smoother u_dut (
    .clk(clk), .rstN(rstN), .validIn(validIn), .filtEn(filtEn), .highVar(highVar),
    .lineIn(lineIn), .validOut(validOut), .lineOut(lineOut)
  );

  function automatic int cs(input int v);
    if (v > 127) return 127;
    if (v < -128) return -128;
    return v;
  endfunction

  function automatic int cu(input int v);
    if (v > 255) return 255;
    if (v < 0) return 0;
    return v;
  endfunction

  function automatic logic [63:0] refLine(input logic [63:0] ln, input bit fe, input bit hv);
    int u [8];
    int w, e, f1, f2, a0, a1, a2;
    logic [63:0] r;
    for (int i = 0; i < 8; i++) u[i] = int'(ln[8*i +: 8]);
    e = cs((u[4] - 128) - (u[3] - 128));
    w = cs((u[2] - 128) - (u[5] - 128));
    w = cs(cs(cs(w + e) + e) + e);
    if (!fe) w = 0;
    if (hv) begin
      f1 = cs(w + 4) >>> 3;
      f2 = cs(w + 3) >>> 3;
      u[3] = cu(u[3] + f2);
      u[4] = cu(u[4] - f1);
    end else begin
      a0 = cs((27 * w + 63) >>> 7);
      a1 = cs((18 * w + 63) >>> 7);
      a2 = cs((9 * w + 63) >>> 7);
      u[3] = cu(u[3] + a0); u[4] = cu(u[4] - a0);
      u[2] = cu(u[2] + a1); u[5] = cu(u[5] - a1);
      u[1] = cu(u[1] + a2); u[6] = cu(u[6] - a2);
    end
    for (int i = 0; i < 8; i++) r[8*i +: 8] = u[i][7:0];
    return r;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkOut();
    chk("R9 valid", {63'b0, validOut}, {63'b0, pv2});
    if (pv2) begin
      chk(pt2, lineOut, pe2);
      lastExp = pe2;
    end else begin
      chk("R9 hold", lineOut, lastExp);
    end
  endtask

  task automatic step(input bit v, input logic [63:0] ln, input bit fe, input bit hv,
                      input logic [63:0] exp, input string tag);
    @(negedge clk);
    checkOut();
    pv2 = pv1; pe2 = pe1; pt2 = pt1;
    validIn = v; lineIn = ln; filtEn = fe; highVar = hv;
    pv1 = v; pe1 = exp; pt1 = tag;
  endtask

  function automatic logic [63:0] shapedLine();
    logic [63:0] r;
    int base, spread;
    base = int'($urandom_range(0, 255));
    spread = int'($urandom_range(0, 40));
    for (int i = 0; i < 8; i++)
      r[8*i +: 8] = 8'(cu(base + int'($urandom_range(0, 2 * spread)) - spread));
    return r;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset valid", {63'b0, validOut}, 64'd0);
    chk("R10 reset line", lineOut, 64'd0);
    rstN = 1'b1;

    // table of directed vectors, back to back, then with gaps
    for (int k = 0; k < NVEC; k++)
      step(1'b1, VEC_IN[k][63:0], VEC_IN[k][65], VEC_IN[k][64], VEC_EXP[k], vecTag[k]);
    for (int k = 0; k < NVEC; k++) begin
      step(1'b1, VEC_IN[k][63:0], VEC_IN[k][65], VEC_IN[k][64], VEC_EXP[k], vecTag[k]);
      step(1'b0, 64'hDEAD_BEEF_0BAD_F00D, 1'b1, 1'b0, '0, "R9");
    end

    // random lines against the reference equations (R1 and all modes)
    for (int k = 0; k < 600; k++) begin
      logic [63:0] ln;
      bit v, fe, hv;
      ln = ($urandom_range(0, 3) == 0) ? {$urandom, $urandom} : shapedLine();
      v  = ($urandom_range(0, 3) != 0);
      fe = ($urandom_range(0, 4) != 0);
      hv = ($urandom_range(0, 2) == 0);
      step(v, ln, fe, hv, refLine(ln, fe, hv), "R1");
    end

    repeat (3) step(1'b0, '0, 1'b0, 1'b0, '0, "R9");

    // reset again with a line in flight
    step(1'b1, VEC_IN[0][63:0], 1'b1, 1'b0, VEC_EXP[0], "R10");
    @(negedge clk);
    rstN = 1'b0;
    validIn = 1'b0;
    #1;
    chk("R10 mid reset valid", {63'b0, validOut}, 64'd0);
    chk("R10 mid reset line", lineOut, 64'd0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog R9 actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

endmodule